// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block runs the bus cycles of one chip select on an external static memory. A client raises a request with a direction, an address and write data while the block is ready. The block latches them and counts clocks from the first cycle in which the address is valid. From that count it places an active-low chip select and either an active-low read strobe or an active-low write strobe. When the programmed cycle length has elapsed it returns to ready and pulses `done` for one clock.

Timing is programmed per direction. Each direction has a setup count and a pulse count for its data strobe, a setup count and a pulse count for its chip select, and a total cycle length. The counts arrive in a compressed code, and the block expands them to clock counts.

The block does not repair a bad configuration. It marks it on `cfg_err` and keeps every strobe inside the cycle.

Top module: `sram_strobe_timer`

## Requirements
- R1: After reset, and after any cycle in which `rst_n` is low, `mem_cs_n`, `mem_rd_n` and `mem_we_n` are 1, `ready` is 1, and `done` and `cfg_err` are 0.
- R2: A 6-bit setup code c expands to `c[4:0]`, plus 128 when `c[5]` is 1.
- R3: A 7-bit pulse code c expands to `c[5:0]`, plus 256 when `c[6]` is 1.
- R4: A 9-bit cycle code c expands to `c[6:0] + 256*c[8:7]`. An expanded cycle length of zero still occupies one clock.
- R5: Let k be the clock index, with k=0 on the first clock after acceptance. Each strobe is low for exactly the clocks setup <= k < setup+pulse of its own pair. Reads use the read strobe and read chip-select pairs and keep `mem_we_n` high. Writes use the write pairs and keep `mem_rd_n` high.
- R6: A cycle of expanded length C (C>0) keeps `ready` low for C clocks. On the next clock `done` is 1 for exactly one clock, together with `ready`.
- R7: A request is taken only when `req_valid` and `ready` are both 1. `mem_addr` and `mem_wdata` hold the values latched at acceptance until `done`. Request activity while busy is ignored.
- R8: A zero pulse code on either strobe of the active direction sets `cfg_err` for the whole cycle. That strobe never goes low.
- R9: When setup+pulse of a strobe exceeds C, `cfg_err` is 1 for the whole cycle and the strobe rises at k = C.
- R10: On a write accepted with `wr_hold_guard` = 1, `mem_cs_n` rises no earlier than `mem_we_n`: the chip-select end is extended to the write-strobe end when that end is later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Idle, able to accept |
| done | output | 1 | One-clock end-of-cycle pulse |
| cfg_err | output | 1 | Current cycle uses an invalid configuration |
| rd_data_setup | input | 6 | Read strobe setup code |
| rd_data_pulse | input | 7 | Read strobe pulse code |
| rd_cs_setup | input | 6 | Chip select setup code, reads |
| rd_cs_pulse | input | 7 | Chip select pulse code, reads |
| rd_cycle | input | 9 | Read cycle length code |
| wr_data_setup | input | 6 | Write strobe setup code |
| wr_data_pulse | input | 7 | Write strobe pulse code |
| wr_cs_setup | input | 6 | Chip select setup code, writes |
| wr_cs_pulse | input | 7 | Chip select pulse code, writes |
| wr_cycle | input | 9 | Write cycle length code |
| wr_hold_guard | input | 1 | Keep chip select low until the write strobe rises |
| mem_addr | output | ADDR_W | Address held for the cycle |
| mem_wdata | output | DATA_W | Write data held for the cycle |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The hardest cases to reach are the ones that need large codes with their upper bits set. Examples are a read strobe that opens at clock 129 and a cycle that lasts 773 clocks, or a chip-select window that overruns a 256-clock cycle and must be cut at its end. The vector table programs such codes directly. The bench follows every strobe edge through cycles hundreds of clocks long and compares the edge positions with values worked out by hand. Further entries cover a zero cycle code, a zero pulse, and the hold guard switched on and off with identical timing, so the chip-select extension can be seen on its own.

// File: rtl/sst_pkg.sv
// Package: shared count type, cycle plan record and code expansion helpers.
// Assumes counts never exceed 895 clocks, so 10 bits suffice.
package sst_pkg;
    localparam int SETUP_CW = 6;
    localparam int PULSE_CW = 7;
    localparam int CYCLE_CW = 9;
    localparam int CNT_W    = CYCLE_CW + 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // Window bounds and length of one accepted cycle.
    typedef struct packed {
        cnt_t dat_start;
        cnt_t dat_stop;
        cnt_t cs_start;
        cnt_t cs_stop;
        cnt_t cyc_len;
        logic err;
    } plan_t;

    // Setup code: the high bit is worth 128, the low five bits are linear.
    function automatic cnt_t expand_setup(input logic [SETUP_CW-1:0] c);
        return (c[SETUP_CW-1] ? cnt_t'(128) : cnt_t'(0)) + cnt_t'(c[SETUP_CW-2:0]);
    endfunction

    // Pulse code: the high bit is worth 256, the low six bits are linear.
    function automatic cnt_t expand_pulse(input logic [PULSE_CW-1:0] c);
        return (c[PULSE_CW-1] ? cnt_t'(256) : cnt_t'(0)) + cnt_t'(c[PULSE_CW-2:0]);
    endfunction

    // Cycle code: the top two bits count units of 256, the low seven are linear.
    function automatic cnt_t expand_cycle(input logic [CYCLE_CW-1:0] c);
        return {c[CYCLE_CW-1:CYCLE_CW-2], 1'b0, c[CYCLE_CW-3:0]};
    endfunction
endpackage

// File: rtl/sst_decode.sv
// Module: sst_decode
// Expands one direction's codes into a cycle plan. Window ends are clamped to
// the cycle length, and an error is flagged for a zero pulse or an overrun.
// With guard set, the chip-select end is pushed out to the data-strobe end.
// Assumes: purely combinational, and codes stay stable while they are sampled.
module sst_decode
    import sst_pkg::*;
(
    input  logic [SETUP_CW-1:0] dat_setup,
    input  logic [PULSE_CW-1:0] dat_pulse,
    input  logic [SETUP_CW-1:0] cs_setup,
    input  logic [PULSE_CW-1:0] cs_pulse,
    input  logic [CYCLE_CW-1:0] cycle,
    input  logic                guard,
    output plan_t               plan
);
    cnt_t d_start, d_len, c_start, c_len, cyc;
    cnt_t d_raw, c_raw, d_clip, c_clip;
    logic d_over, c_over, zero_pulse;

    // Expand the codes and clip each window to the cycle end.
    always_comb begin
        d_start    = expand_setup(dat_setup);
        d_len      = expand_pulse(dat_pulse);
        c_start    = expand_setup(cs_setup);
        c_len      = expand_pulse(cs_pulse);
        cyc        = expand_cycle(cycle);
        d_raw      = d_start + d_len;
        c_raw      = c_start + c_len;
        d_over     = d_raw > cyc;
        c_over     = c_raw > cyc;
        zero_pulse = (d_len == '0) || (c_len == '0);
        d_clip     = d_over ? cyc : d_raw;
        c_clip     = c_over ? cyc : c_raw;
    end

    // Assemble the plan, applying the guard extension and the one-clock floor.
    always_comb begin
        plan.dat_start = d_start;
        plan.dat_stop  = d_clip;
        plan.cs_start  = c_start;
        plan.cs_stop   = (guard && (d_clip > c_clip)) ? d_clip : c_clip;
        plan.cyc_len   = (cyc == '0) ? cnt_t'(1) : cyc;
        plan.err       = zero_pulse || d_over || c_over;
    end
endmodule

// File: rtl/sst_seq.sv
// Module: sst_seq
// Accepts one request in idle, latches the request and its plan, counts the
// cycle clocks and pulses done at the end. Assumes plan.cyc_len >= 1.
module sst_seq
    import sst_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  plan_t             plan_in,
    input  logic              guard_in,
    output logic              ready,
    output logic              busy,
    output logic              done,
    output logic              is_write,
    output logic              guard_q,
    output cnt_t              cnt,
    output plan_t             plan_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    typedef enum logic {S_IDLE, S_RUN} state_t;
    state_t state;
    logic   last;

    // Flag the final clock of the running cycle.
    always_comb last = (cnt == plan_q.cyc_len - cnt_t'(1));

    // Step the state machine, latch on acceptance, count and end the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            done     <= 1'b0;
            is_write <= 1'b0;
            guard_q  <= 1'b0;
            plan_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        state    <= S_RUN;
                        cnt      <= '0;
                        is_write <= req_write;
                        guard_q  <= req_write && guard_in;
                        plan_q   <= plan_in;
                        addr_q   <= req_addr;
                        wdata_q  <= req_wdata;
                    end
                end
                default: begin
                    if (last) begin
                        state <= S_IDLE;
                        cnt   <= '0;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
            endcase
        end
    end

    // Decode the idle and busy indications.
    always_comb begin
        ready = (state == S_IDLE);
        busy  = (state == S_RUN);
    end
endmodule

// File: rtl/sst_window.sv
// Module: sst_window
// Drives one active-low strobe, low while enabled and start <= cnt < stop.
// Assumes: all inputs come from flops, so the output is a decode of state.
module sst_window
    import sst_pkg::*;
(
    input  logic en,
    input  cnt_t cnt,
    input  cnt_t start,
    input  cnt_t stop,
    output logic strobe_n
);
    // Compare the counter against the window bounds.
    always_comb strobe_n = !(en && (cnt >= start) && (cnt < stop));
endmodule

// File: rtl/sram_strobe_timer.sv
// Module: sram_strobe_timer (top)
// Static memory cycle timer for one chip select. Expands the read and write
// timing codes, selects a plan by direction on acceptance, and derives the
// chip-select, read and write strobes from the cycle counter.
// Assumes: timing codes stay stable while a request is offered.
module sram_strobe_timer
    import sst_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic              cfg_err,
    input  logic [5:0]        rd_data_setup,
    input  logic [6:0]        rd_data_pulse,
    input  logic [5:0]        rd_cs_setup,
    input  logic [6:0]        rd_cs_pulse,
    input  logic [8:0]        rd_cycle,
    input  logic [5:0]        wr_data_setup,
    input  logic [6:0]        wr_data_pulse,
    input  logic [5:0]        wr_cs_setup,
    input  logic [6:0]        wr_cs_pulse,
    input  logic [8:0]        wr_cycle,
    input  logic              wr_hold_guard,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n
);
    localparam int NSTRB = 3;   // 0 chip select, 1 read, 2 write

    plan_t rd_plan, wr_plan, sel_plan, plan_q;
    logic  busy, is_write, guard_q;
    cnt_t  cnt;
    logic [NSTRB-1:0] w_en, w_n;
    cnt_t  w_start [NSTRB];
    cnt_t  w_stop  [NSTRB];

    sst_decode u_rd_dec (
        .dat_setup (rd_data_setup),
        .dat_pulse (rd_data_pulse),
        .cs_setup  (rd_cs_setup),
        .cs_pulse  (rd_cs_pulse),
        .cycle     (rd_cycle),
        .guard     (1'b0),
        .plan      (rd_plan)
    );

    sst_decode u_wr_dec (
        .dat_setup (wr_data_setup),
        .dat_pulse (wr_data_pulse),
        .cs_setup  (wr_cs_setup),
        .cs_pulse  (wr_cs_pulse),
        .cycle     (wr_cycle),
        .guard     (wr_hold_guard),
        .plan      (wr_plan)
    );

    // Pick the plan matching the offered direction.
    always_comb sel_plan = req_write ? wr_plan : rd_plan;

    sst_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .plan_in   (sel_plan),
        .guard_in  (wr_hold_guard),
        .ready     (ready),
        .busy      (busy),
        .done      (done),
        .is_write  (is_write),
        .guard_q   (guard_q),
        .cnt       (cnt),
        .plan_q    (plan_q),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata)
    );

    // Route window bounds and enables to the three strobe generators.
    always_comb begin
        w_en[0]    = busy;
        w_start[0] = plan_q.cs_start;
        w_stop[0]  = plan_q.cs_stop;
        w_en[1]    = busy && !is_write;
        w_start[1] = plan_q.dat_start;
        w_stop[1]  = plan_q.dat_stop;
        w_en[2]    = busy && is_write;
        w_start[2] = plan_q.dat_start;
        w_stop[2]  = plan_q.dat_stop;
    end

    for (genvar g = 0; g < NSTRB; g++) begin : g_win
        sst_window u_win (
            .en       (w_en[g]),
            .cnt      (cnt),
            .start    (w_start[g]),
            .stop     (w_stop[g]),
            .strobe_n (w_n[g])
        );
    end

    // Present strobes and the error flag on the ports.
    always_comb begin
        mem_cs_n = w_n[0];
        mem_rd_n = w_n[1];
        mem_we_n = w_n[2];
        cfg_err  = busy && plan_q.err;
    end
endmodule

// File: rtl/sst_checker.sv
// Module: sst_checker
// Protocol properties of sram_strobe_timer, attached by bind.
module sst_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ready,
    input logic              done,
    input logic              cfg_err,
    input logic              guard_q,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_rd_n && mem_we_n && !cfg_err));

    a_r5_one_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_we_n));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(mem_addr));

    a_r10_cs_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_cs_n) && guard_q) |-> mem_we_n);
endmodule

bind sram_strobe_timer sst_checker #(.ADDR_W(ADDR_W)) u_sst_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .done      (done),
    .cfg_err   (cfg_err),
    .guard_q   (guard_q),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr)
);

// File: tb/sram_strobe_timer_tb.sv
module sram_strobe_timer_tb;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int NONE = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready, done, cfg_err, mem_cs_n, mem_rd_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [5:0] rds = '0, rcs = '0, wds = '0, wcs = '0;
    logic [6:0] rdp = 7'd1, rcp = 7'd1, wdp = 7'd1, wcp = 7'd1;
    logic [8:0] rcy = 9'd2, wcy = 9'd2;
    logic guard = 1'b0;

    int checks = 0;
    int fails = 0;

    always #5ns clk = ~clk;

    sram_strobe_timer #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
        .cfg_err(cfg_err), .rd_data_setup(rds), .rd_data_pulse(rdp),
        .rd_cs_setup(rcs), .rd_cs_pulse(rcp), .rd_cycle(rcy),
        .wr_data_setup(wds), .wr_data_pulse(wdp), .wr_cs_setup(wcs),
        .wr_cs_pulse(wcp), .wr_cycle(wcy), .wr_hold_guard(guard),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n)
    );

    typedef struct packed {
        logic       wr;
        logic       grd;
        logic [5:0] ds;
        logic [6:0] dp;
        logic [5:0] cs;
        logic [6:0] cp;
        logic [8:0] cy;
        logic [10:0] e_d0, e_d1, e_c0, e_c1, e_cyc;
        logic       e_err;
    } vec_t;

    // Expected windows worked out by hand from R2..R5, R8, R9, R10.
    localparam vec_t TBL [8] = '{
        '{1'b0, 1'b0, 6'd2,  7'd3,  6'd0, 7'd6,  9'd8,   11'd2,   11'd5,   11'd0,   11'd6,   11'd8,   1'b0},
        '{1'b0, 1'b0, 6'h21, 7'h41, 6'd0, 7'h40, 9'h185, 11'd129, 11'd386, 11'd0,   11'd256, 11'd773, 1'b0},
        '{1'b0, 1'b0, 6'd5,  7'd10, 6'd0, 7'd4,  9'd9,   11'd5,   11'd9,   11'd0,   11'd4,   11'd9,   1'b1},
        '{1'b0, 1'b0, 6'd1,  7'd0,  6'd0, 7'd3,  9'd5,   11'd1023,11'd1023,11'd0,   11'd3,   11'd5,   1'b1},
        '{1'b1, 1'b0, 6'd1,  7'd4,  6'd0, 7'd3,  9'd7,   11'd1,   11'd5,   11'd0,   11'd3,   11'd7,   1'b0},
        '{1'b1, 1'b1, 6'd1,  7'd4,  6'd0, 7'd3,  9'd7,   11'd1,   11'd5,   11'd0,   11'd5,   11'd7,   1'b0},
        '{1'b1, 1'b0, 6'h20, 7'h3F, 6'd0, 7'h7F, 9'h080, 11'd128, 11'd191, 11'd0,   11'd256, 11'd256, 1'b1},
        '{1'b0, 1'b0, 6'd0,  7'd1,  6'd0, 7'd1,  9'd0,   11'd1023,11'd1023,11'd1023,11'd1023,11'd1,   1'b1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int m_d0, m_d1, m_c0, m_c1, m_cyc, m_err, m_other;

    // Issue one request and record strobe edge positions by clock index.
    task automatic run_txn(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int k;
        logic dn;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        m_d0 = NONE; m_d1 = NONE; m_c0 = NONE; m_c1 = NONE; m_cyc = -1; m_other = 0;
        m_err = cfg_err;
        k = 0;
        while (k < 2000) begin
            dn = wr ? mem_we_n : mem_rd_n;
            if (!dn && m_d0 == NONE) m_d0 = k;
            if (dn && m_d0 != NONE && m_d1 == NONE) m_d1 = k;
            if (!mem_cs_n && m_c0 == NONE) m_c0 = k;
            if (mem_cs_n && m_c0 != NONE && m_c1 == NONE) m_c1 = k;
            if (!(wr ? mem_rd_n : mem_we_n)) m_other++;
            if (done) begin
                m_cyc = k;
                break;
            end
            k++;
            @(negedge clk);
        end
    endtask

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cs_n", mem_cs_n, 1);
        check("R1", "rd_n", mem_rd_n, 1);
        check("R1", "we_n", mem_we_n, 1);
        check("R1", "ready", ready, 1);
        check("R1", "done", done, 0);
        rst_n = 1'b1;

        // Vector walk: R2 R3 R4 R5 R6 R8 R9 R10
        foreach (TBL[i]) begin
            vec_t v;
            v = TBL[i];
            guard = v.grd;
            if (v.wr) begin
                wds = v.ds; wdp = v.dp; wcs = v.cs; wcp = v.cp; wcy = v.cy;
                rds = 6'd1; rdp = 7'd1; rcs = 6'd0; rcp = 7'd2; rcy = 9'd3;
            end else begin
                rds = v.ds; rdp = v.dp; rcs = v.cs; rcp = v.cp; rcy = v.cy;
                wds = 6'd1; wdp = 7'd1; wcs = 6'd0; wcp = 7'd2; wcy = 9'd3;
            end
            run_txn(v.wr, AW'(24'h100 + i), DW'(16'hA000 + i));
            check("R2_R5", $sformatf("v%0d data start", i), m_d0, int'(v.e_d0));
            check("R3_R9_R8", $sformatf("v%0d data stop", i), m_d1, int'(v.e_d1));
            check("R5", $sformatf("v%0d cs start", i), m_c0, int'(v.e_c0));
            check("R10_R9", $sformatf("v%0d cs stop", i), m_c1, int'(v.e_c1));
            check("R4_R6", $sformatf("v%0d cycle length", i), m_cyc, int'(v.e_cyc));
            check("R8_R9", $sformatf("v%0d cfg_err", i), m_err, int'(v.e_err));
            check("R5", $sformatf("v%0d other strobe low clocks", i), m_other, 0);
        end

        // R6: done lasts one clock and ready is back with it
        guard = 1'b0;
        rds = 6'd1; rdp = 7'd2; rcs = 6'd0; rcp = 7'd4; rcy = 9'd4;
        run_txn(1'b0, 24'h55AA11, 16'h1234);
        check("R6", "ready with done", ready, 1);
        @(negedge clk);
        check("R6", "done one clock", done, 0);

        // R7: latching, and request activity during a busy cycle is ignored
        rcy = 9'd20;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'hABCDEF; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h000001; req_wdata = 16'h0001;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7", "addr held", int'(mem_addr), int'(24'hABCDEF));
        check("R7", "wdata held", int'(mem_wdata), int'(16'hBEEF));
        check("R7", "no write strobe from ignored request", mem_we_n, 1);
        check("R7", "still busy", ready, 0);
        begin
            int dones = 0;
            for (int t = 0; t < 30; t++) begin
                @(negedge clk);
                if (done) dones++;
            end
            check("R7", "single done", dones, 1);
        end
        check("R7", "idle after ignored request", ready, 1);

        // R1: reset in the middle of a cycle
        rcs = 6'd0; rcp = 7'd10; rcy = 9'd20;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "cs low before mid reset", mem_cs_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "cs after mid reset", mem_cs_n, 1);
        check("R1", "ready after mid reset", ready, 1);
        check("R1", "cfg_err after mid reset", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule